// File: doc/BRIEF.md
# Multi-Source Reset Controller with USB Bus Reset Routing

This block merges every reset request on the chip into two reset outputs. One holds the microcontroller core. The other holds the USB logic. The requests come from four places:

- power-on
- an active-low external reset pin, which is synchronised and filtered against glitches
- a single-cycle watchdog timeout
- a USB bus reset, recognised when both upstream data lines stay low (single-ended zero, SE0) for a minimum time

A core reset does not end when its source goes away. The core stays held through a start-up delay. That delay counts ticks of a slow time base, about 1 MHz, divided down from the system clock. The delay begins on the clock edge after the last edge at which any core source was active.

A recognised bus reset always produces a fixed-length pulse on the USB reset. A mode input chooses what else happens:

- **Joined mode:** the same pulse also drives the core through the start-up delay.
- **Separated mode:** only the USB logic is reset, and the CPU receives a one-cycle interrupt if a mask input allows it.

A cause register records which sources have fired. Software clears its bits by writing ones.

Top module: `reset_ctrl`

## Requirements
- R1: While `por` is high, `core_rst` and `usb_rst` are high and `cause` reads 4'b0001. `core_rst` falls exactly TICK_DIV*DELAY_TICKS clock cycles after the last rising clock edge at which `por` was sampled high.
- R2: The external pin is accepted only after its synchronised value has been low for EXT_MIN_LOW consecutive clocks. A shorter low pulse leaves `core_rst` low and `cause[1]` clear.
- R3: After an accepted external reset, `core_rst` stays high while the pin is low. Once the pin is released, `core_rst` falls TICK_DIV*DELAY_TICKS+3 cycles after the last clock edge that sampled the pin low; the extra 3 cycles are 2 synchroniser stages and 1 filter register.
- R4: A one-cycle `wdt_timeout` raises `core_rst` on the following cycle. `core_rst` then stays high for exactly TICK_DIV*DELAY_TICKS cycles.
- R5: A bus reset is recognised when the synchronised `usb_dp` and `usb_dm` are both low for LS_BIT_CLKS*SE0_BITS consecutive clocks. A shorter SE0 has no effect. An SE0 held longer than that still counts as a single event.
- R6: Each recognised bus reset holds `usb_rst` high for exactly BUS_PULSE_CLKS cycles, unless a core reset is holding it at the same time.
- R7: In joined mode (`bus_sep_en`=0), a bus reset also drives `core_rst`. `core_rst` rises one cycle after `usb_rst` and falls TICK_DIV*DELAY_TICKS cycles after the USB pulse ends.
- R8: In separated mode (`bus_sep_en`=1), a bus reset leaves `core_rst` low. `bus_irq` gives one single-cycle pulse per event if `bus_irq_mask`=1, and no pulse if it is 0.
- R9: `cause` bit 0 records power-on, bit 1 the external pin, bit 2 the watchdog and bit 3 a bus reset in either mode. Bits are sticky. Writing a 1 in `cause_clr` clears that bit. A new event for a bit in the same cycle as its clear wins.
- R10: `usb_rst` is high whenever `core_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on request, active high, synchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog expiry, one-cycle pulse |
| usb_dp | input | 1 | Upstream D+ line state, asynchronous |
| usb_dm | input | 1 | Upstream D- line state, asynchronous |
| bus_sep_en | input | 1 | 1 = bus reset resets USB logic only |
| bus_irq_mask | input | 1 | 1 = allow bus-reset interrupt in separated mode |
| cause_clr | input | 4 | Write-one-to-clear strobes for `cause` |
| core_rst | output | 1 | Core reset, active high |
| usb_rst | output | 1 | USB logic reset, active high |
| bus_irq | output | 1 | Bus-reset interrupt, one-cycle pulse |
| cause | output | 4 | Sticky reset-cause flags |

## Verification
The assertions assume the following about the inputs:

- `wdt_timeout` arrives as a clean synchronous pulse.
- The mode and mask inputs stay steady around the cycle in which a bus reset is recognised, because the interrupt check looks one cycle back at them.

The stimulus meets these assumptions:

- It changes every input only on the falling clock edge.
- It sets the mode and mask bits many cycles before it drives an SE0.
- It drives the asynchronous pin and line inputs for whole cycles, so their timing through the synchronisers is exact and the release counts can be checked to the cycle.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    // Bit positions inside the cause register
    localparam int CAUSE_PWR = 0;
    localparam int CAUSE_EXT = 1;
    localparam int CAUSE_WDT = 2;
    localparam int CAUSE_BUS = 3;
    localparam int CAUSE_W   = 4;

    typedef struct packed {
        logic bus;
        logic wdt;
        logic ext;
        logic pwr;
    } cause_t;

    // Source requests feeding the core hold path
    typedef struct packed {
        logic ext_hold;
        logic wdt_pulse;
        logic bus_hold;
    } core_req_t;

    // Sticky update: clear first, then new events win
    function automatic cause_t cause_next(cause_t cur, logic [CAUSE_W-1:0] clr, cause_t set);
        return cause_t'((cur & ~clr) | set);
    endfunction

    function automatic logic any_req(core_req_t r);
        return r.ext_hold | r.wdt_pulse | r.bus_hold;
    endfunction

endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic hold,
    output logic accept
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic          sync1, sync2;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1   <= 1'b1;
            sync2   <= 1'b1;
            low_cnt <= '0;
            hold    <= 1'b0;
            accept  <= 1'b0;
        end else begin
            sync1  <= pin_n;
            sync2  <= sync1;
            accept <= 1'b0;
            if (sync2) begin
                low_cnt <= '0;
                hold    <= 1'b0;
            end else if (!hold) begin
                if (low_cnt == CW'(MIN_LOW - 1)) begin
                    hold   <= 1'b1;
                    accept <= 1'b1;
                end else begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rstc_se0_detect.sv
module rstc_se0_detect #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic dp,
    input  logic dm,
    output logic evt
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [1:0]    sync1, sync2;
    logic [CW-1:0] cnt;
    logic          fired;
    logic          se0;

    assign se0 = (sync2 == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 2'b01;
            sync2 <= 2'b01;
            cnt   <= '0;
            fired <= 1'b0;
            evt   <= 1'b0;
        end else begin
            sync1 <= {dp, dm};
            sync2 <= sync1;
            evt   <= 1'b0;
            if (!se0) begin
                cnt   <= '0;
                fired <= 1'b0;
            end else if (!fired) begin
                if (cnt == CW'(LIMIT - 1)) begin
                    fired <= 1'b1;
                    evt   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rstc_pulse.sv
module rstc_pulse #(
    parameter int LEN = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (trig)
            left <= CW'(LEN);
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign active = (left != '0);
endmodule

// File: rtl/rstc_delay.sv
module rstc_delay #(
    parameter int TICK_DIV    = 12,
    parameter int DELAY_W     = 14,
    parameter int DELAY_TICKS = 16383
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic busy
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0]      pre;
    logic [DELAY_W-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            busy  <= 1'b1;
            pre   <= '0;
            ticks <= '0;
        end else if (busy) begin
            if (pre == PW'(TICK_DIV - 1)) begin
                pre <= '0;
                if (ticks == DELAY_W'(DELAY_TICKS - 1))
                    busy <= 1'b0;
                else
                    ticks <= ticks + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/reset_ctrl.sv
module reset_ctrl
    import rstc_pkg::*;
#(
    parameter int TICK_DIV       = 12,
    parameter int DELAY_W        = 14,
    parameter int DELAY_TICKS    = 16383,
    parameter int EXT_MIN_LOW    = 4,
    parameter int LS_BIT_CLKS    = 8,
    parameter int SE0_BITS       = 4,
    parameter int BUS_PULSE_CLKS = 24
) (
    input  logic                clk,
    input  logic                por,
    input  logic                ext_rst_n,
    input  logic                wdt_timeout,
    input  logic                usb_dp,
    input  logic                usb_dm,
    input  logic                bus_sep_en,
    input  logic                bus_irq_mask,
    input  logic [CAUSE_W-1:0]  cause_clr,
    output logic                core_rst,
    output logic                usb_rst,
    output logic                bus_irq,
    output logic [CAUSE_W-1:0]  cause
);
    localparam int SE0_CLKS = LS_BIT_CLKS * SE0_BITS;

    logic      ext_hold, ext_accept;
    logic      bus_evt, pulse_on, delay_busy;
    core_req_t req;
    cause_t    cause_q, cause_set;

    rstc_pin_filter #(.MIN_LOW(EXT_MIN_LOW)) u_pin (
        .clk(clk), .rst(por), .pin_n(ext_rst_n), .hold(ext_hold), .accept(ext_accept)
    );

    rstc_se0_detect #(.LIMIT(SE0_CLKS)) u_se0 (
        .clk(clk), .rst(por), .dp(usb_dp), .dm(usb_dm), .evt(bus_evt)
    );

    rstc_pulse #(.LEN(BUS_PULSE_CLKS)) u_pulse (
        .clk(clk), .rst(por), .trig(bus_evt), .active(pulse_on)
    );

    always_comb begin
        req.ext_hold  = ext_hold;
        req.wdt_pulse = wdt_timeout;
        req.bus_hold  = pulse_on & ~bus_sep_en;
    end

    rstc_delay #(
        .TICK_DIV(TICK_DIV), .DELAY_W(DELAY_W), .DELAY_TICKS(DELAY_TICKS)
    ) u_delay (
        .clk(clk), .rst(por), .hold(any_req(req)), .busy(delay_busy)
    );

    always_comb begin
        cause_set     = '0;
        cause_set.ext = ext_accept;
        cause_set.wdt = wdt_timeout;
        cause_set.bus = bus_evt;
    end

    always_ff @(posedge clk) begin
        if (por) begin
            cause_q     <= '0;
            cause_q.pwr <= 1'b1;
            bus_irq     <= 1'b0;
        end else begin
            cause_q <= cause_next(cause_q, cause_clr, cause_set);
            bus_irq <= bus_evt & bus_sep_en & bus_irq_mask;
        end
    end

    assign core_rst = delay_busy;
    assign usb_rst  = delay_busy | pulse_on;
    assign cause    = cause_q;
endmodule

// File: rtl/reset_ctrl_chk.sv
module reset_ctrl_chk (
    input logic clk,
    input logic por,
    input logic wdt_timeout,
    input logic bus_sep_en,
    input logic bus_irq_mask,
    input logic core_rst,
    input logic usb_rst,
    input logic bus_irq
);
    // R1: core still held in the cycle after power-on is released
    a_r1_por_release_holds: assert property (@(posedge clk) disable iff (por)
        $fell(por) |-> core_rst);

    // R4: watchdog timeout reaches the core reset next cycle
    a_r4_wdt_resets_core: assert property (@(posedge clk) disable iff (por)
        wdt_timeout |=> core_rst);

    // R10: USB reset covers every core reset
    a_r10_usb_covers_core: assert property (@(posedge clk) disable iff (por)
        core_rst |-> usb_rst);

    // R8: interrupt only in separated mode with mask set
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (por)
        bus_irq |-> $past(bus_sep_en && bus_irq_mask));

    // R8: interrupt is a single-cycle pulse
    a_r8_irq_single: assert property (@(posedge clk) disable iff (por)
        bus_irq |=> !bus_irq);

    // R6: a bus pulse alone lasts longer than one cycle
    a_r6_usb_pulse_len: assert property (@(posedge clk) disable iff (por)
        ($rose(usb_rst) && !core_rst) |=> usb_rst);
endmodule

bind reset_ctrl reset_ctrl_chk u_chk (.*);

// File: tb/tb_reset_ctrl.sv
module tb_reset_ctrl;
    localparam int DIV   = 4;
    localparam int TICKS = 8;
    localparam int MINL  = 5;
    localparam int LSB   = 2;
    localparam int SE0B  = 4;
    localparam int PULSE = 24;
    localparam int DLY   = DIV * TICKS;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       wdt_timeout = 1'b0;
    logic       usb_dp = 1'b1;
    logic       usb_dm = 1'b0;
    logic       bus_sep_en = 1'b0;
    logic       bus_irq_mask = 1'b0;
    logic [3:0] cause_clr = 4'b0;
    logic       core_rst, usb_rst, bus_irq;
    logic [3:0] cause;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    reset_ctrl #(
        .TICK_DIV(DIV), .DELAY_W(14), .DELAY_TICKS(TICKS), .EXT_MIN_LOW(MINL),
        .LS_BIT_CLKS(LSB), .SE0_BITS(SE0B), .BUS_PULSE_CLKS(PULSE)
    ) dut (
        .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout),
        .usb_dp(usb_dp), .usb_dm(usb_dm), .bus_sep_en(bus_sep_en),
        .bus_irq_mask(bus_irq_mask), .cause_clr(cause_clr),
        .core_rst(core_rst), .usb_rst(usb_rst), .bus_irq(bus_irq), .cause(cause)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count consecutive falling edges with the chosen reset high, current one included
    task automatic run_len(input bit use_usb, output int n);
        n = 0;
        while ((use_usb ? usb_rst : core_rst) && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_power_on;
        int n;
        repeat (5) @(negedge clk);
        chk("R1 core_rst during por", core_rst, 1);
        chk("R1 usb_rst during por", usb_rst, 1);
        chk("R1 cause after por", cause, 4'b0001);
        por = 1'b0;
        run_len(1'b0, n);
        chk("R1 release delay", n, DLY);
        chk("R1 cause kept", cause, 4'b0001);
    endtask

    task automatic t_watchdog;
        int n;
        @(negedge clk);
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
        chk("R10 usb_rst with wdt core reset", usb_rst, 1);
        run_len(1'b0, n);
        chk("R4 watchdog reset length", n, DLY);
        chk("R9 wdt cause bit2", cause[2], 1);
    endtask

    task automatic t_ext_glitch;
        int seen = 0;
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (MINL - 1) @(negedge clk);
        ext_rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            seen += core_rst;
        end
        chk("R2 short low rejected", seen, 0);
        chk("R2 cause bit1 clear after glitch", cause[1], 0);
    endtask

    task automatic t_ext_reset;
        int n;
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (12) @(negedge clk);
        chk("R2 long low accepted", core_rst, 1);
        chk("R9 ext cause bit1", cause[1], 1);
        ext_rst_n = 1'b1;
        run_len(1'b0, n);
        chk("R3 release delay after pin", n, DLY + 3);
    endtask

    // Drive an SE0 of se0_len cycles and tally outputs over win cycles
    task automatic se0_run(input int se0_len, input int win,
                           output int usb_n, output int core_n, output int irq_n);
        usb_n = 0; core_n = 0; irq_n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            usb_n  += usb_rst;
            core_n += core_rst;
            irq_n  += bus_irq;
            if (i < se0_len) begin
                usb_dp = 1'b0; usb_dm = 1'b0;
            end else begin
                usb_dp = 1'b1; usb_dm = 1'b0;
            end
        end
    endtask

    task automatic t_se0_short;
        int u, c, q;
        se0_run(LSB * SE0B - 1, 60, u, c, q);
        chk("R5 short SE0 no usb reset", u, 0);
        chk("R5 short SE0 no cause", cause[3], 0);
    endtask

    task automatic t_sep_masked;
        int u, c, q;
        bus_sep_en = 1'b1; bus_irq_mask = 1'b1;
        repeat (3) @(negedge clk);
        se0_run(60, 150, u, c, q);
        chk("R6 R5 single pulse for long SE0", u, PULSE);
        chk("R8 core untouched separated", c, 0);
        chk("R8 one irq with mask", q, 1);
        chk("R9 bus cause bit3", cause[3], 1);
    endtask

    task automatic t_sep_unmasked;
        int u, c, q;
        bus_irq_mask = 1'b0;
        repeat (3) @(negedge clk);
        se0_run(12, 80, u, c, q);
        chk("R6 pulse length unmasked", u, PULSE);
        chk("R8 no irq without mask", q, 0);
        chk("R8 core untouched unmasked", c, 0);
    endtask

    task automatic t_joined;
        int u, c, q;
        bus_sep_en = 1'b0;
        repeat (3) @(negedge clk);
        se0_run(12, 140, u, c, q);
        chk("R7 core held joined mode", c, PULSE + DLY - 1);
        chk("R7 usb_rst span joined mode", u, PULSE + DLY);
        chk("R7 no irq joined mode", q, 0);
    endtask

    task automatic t_cause_clear;
        int n;
        @(negedge clk);
        chk("R9 all causes set", cause, 4'b1111);
        cause_clr = 4'b0110;
        @(negedge clk);
        cause_clr = 4'b0000;
        chk("R9 w1c clears selected", cause, 4'b1001);
        cause_clr = 4'b0100;
        wdt_timeout = 1'b1;
        @(negedge clk);
        cause_clr = 4'b0000;
        wdt_timeout = 1'b0;
        chk("R9 set wins over clear", cause[2], 1);
        run_len(1'b0, n);
        chk("R4 second watchdog length", n, DLY);
    endtask

    initial begin
        t_power_on();
        t_watchdog();
        t_ext_glitch();
        t_ext_reset();
        t_se0_short();
        t_sep_masked();
        t_sep_unmasked();
        t_joined();
        t_cause_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule